// File: doc/BRIEF.md
# Resonance-Timed Setpoint Ramp Generator

This block sits between a current setpoint register and a 10-bit current DAC. It does not step the DAC code when the host writes a new setpoint. It moves the code in single-code steps along a straight line from its present value to the new target. The line spans exactly one mechanical resonance period of the spring-mounted load, so the load settles without ringing. The resonance frequency comes from an 8-bit code that selects 50 Hz plus 0.4 Hz per count, which covers 50 Hz to 152 Hz. The period for each code is a clock-cycle count held in a table, which is computed at elaboration from the clock frequency parameter.

Step timing comes from a fractional accumulator. The accumulator adds the code distance on every clock and subtracts the period count whenever a step is due, so the last step lands exactly on the target. The ramp does not aim to match the true resonance exactly: one full period of linear travel still works when the real frequency is up to ±20% away from the programmed one. A write with a changed value starts a new ramp from wherever the output stands. The output is driven only while the active-mode enable is high.

Top module: `vcm_ramp_gen`

## Requirements
- R1: After reset, `dac_code` is 0 and `ramp_busy` is 0.
- R2: A write (`setpoint_wr` high with `active_en` high) whose `setpoint` differs from `dac_code` starts a ramp. From the edge that samples the write, `ramp_busy` is high for exactly N clock cycles, where N = floor(CLK_HZ*10 / (500 + 4*res_code)), with `res_code` sampled on that write. The parameters must make N at least 2^CODE_W for every code.
- R3: During the ramp from start S to target T, with D = |T - S|, the output j edges after the write edge equals S + floor(D*j/N) when rising, or S - floor(D*j/N) when falling. It therefore moves by at most one code per cycle and holds its value on the write edge itself.
- R4: At j = N the output equals T exactly, and it never passes T. It then stays at T while no write arrives.
- R5: A changed write that arrives during a ramp starts a new ramp from the present output value, timed by the newly sampled `res_code`.
- R6: A write whose `setpoint` equals the present `dac_code` starts no ramp. `ramp_busy` is 0 on the next cycle, any ramp in progress stops, and the output holds its value.
- R7: While `active_en` is low, each edge forces `dac_code` to 0 and `ramp_busy` to 0, which cancels any ramp. Writes seen while `active_en` is low are ignored.
- R8: When `active_en` returns high, the output rests at 0 until a changed write arrives, and the next ramp starts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_en | input | 1 | High while the driver is in active mode |
| setpoint | input | CODE_W | New target current code |
| setpoint_wr | input | 1 | One-cycle strobe qualifying `setpoint` |
| res_code | input | FREQ_W | Resonance frequency code, 50 Hz + 0.4 Hz per count |
| dac_code | output | CODE_W | Current code sent to the DAC |
| ramp_busy | output | 1 | High while a ramp is in progress |

## Verification
The bench builds the block with CLK_HZ = 160000, leaving CODE_W, FREQ_W and the frequency scale at their defaults. With that clock, periods run from 1052 cycles at code 255 to 3200 cycles at code 0. Full ramps, including a full-scale ramp of 1023 codes, therefore finish within a few thousand cycles, and every cycle of each ramp can be compared with the floor formula. This choice still keeps the distance below the period, as the single-step accumulator requires. The default 24 MHz clock gives periods of 157894 to 480000 cycles, which exercises the table width but is too long to run through in the bench.

// File: rtl/vcm_ramp_pkg.sv
package vcm_ramp_pkg;

  typedef enum logic {RAMP_DOWN = 1'b0, RAMP_UP = 1'b1} ramp_dir_t;

  // Clock cycles in one resonance period for a frequency code.
  // Frequencies are in tenths of a hertz to keep the 0.4 Hz step integral.
  function automatic longint period_cycles(longint clk_hz, longint base_dhz,
                                           longint step_dhz, longint code);
    return (clk_hz * 10) / (base_dhz + step_dhz * code);
  endfunction

endpackage

// File: rtl/vcm_period_rom.sv
module vcm_period_rom #(
  parameter longint CLK_HZ   = 24_000_000,
  parameter int     BASE_DHZ = 500,
  parameter int     STEP_DHZ = 4,
  parameter int     FREQ_W   = 8,
  parameter int     PER_W    = 19
) (
  input  logic [FREQ_W-1:0] code,
  output logic [PER_W-1:0]  period
);
  localparam int NCODES = 1 << FREQ_W;

  logic [PER_W-1:0] tbl [NCODES];

  for (genvar i = 0; i < NCODES; i++) begin : g_entry
    assign tbl[i] = PER_W'(vcm_ramp_pkg::period_cycles(CLK_HZ, longint'(BASE_DHZ),
                                                       longint'(STEP_DHZ), longint'(i)));
  end

  assign period = tbl[code];
endmodule

// File: rtl/vcm_step_accum.sv
module vcm_step_accum #(
  parameter int CODE_W = 10,
  parameter int PER_W  = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic [CODE_W-1:0] delta_in,
  input  logic [PER_W-1:0]  period_in,
  output logic              step,
  output logic              done,
  output logic              active
);
  logic [PER_W-1:0]  acc;
  logic [PER_W-1:0]  cnt;
  logic [CODE_W-1:0] d_q;
  logic [PER_W-1:0]  n_q;
  logic [PER_W:0]    sum;
  logic              hit;

  assign sum  = {1'b0, acc} + (PER_W+1)'(d_q);
  assign hit  = sum >= {1'b0, n_q};
  assign step = active && hit;
  assign done = active && (cnt == n_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      cnt    <= '0;
      d_q    <= '0;
      n_q    <= '0;
      active <= 1'b0;
    end else if (load) begin
      acc    <= '0;
      cnt    <= '0;
      d_q    <= delta_in;
      n_q    <= period_in;
      active <= 1'b1;
    end else if (clear) begin
      acc    <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (active) begin
      acc    <= hit ? PER_W'(sum - {1'b0, n_q}) : sum[PER_W-1:0];
      cnt    <= cnt + 1'b1;
      if (done) active <= 1'b0;
    end
  end

  // R2: ramp count stays inside the latched period
  assert_count_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt < n_q);

  // R2: the last counted cycle ends the ramp
  assert_done_ends_ramp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done && !load |=> !active);

  // R3: fractional remainder stays below the period while running
  assert_remainder_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> acc < n_q);
endmodule

// File: rtl/vcm_ramp_gen.sv
module vcm_ramp_gen #(
  parameter int     CODE_W   = 10,
  parameter int     FREQ_W   = 8,
  parameter longint CLK_HZ   = 24_000_000,
  parameter int     BASE_DHZ = 500,
  parameter int     STEP_DHZ = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_en,
  input  logic [CODE_W-1:0] setpoint,
  input  logic              setpoint_wr,
  input  logic [FREQ_W-1:0] res_code,
  output logic [CODE_W-1:0] dac_code,
  output logic              ramp_busy
);
  import vcm_ramp_pkg::*;

  localparam longint MAX_PER = period_cycles(CLK_HZ, longint'(BASE_DHZ),
                                             longint'(STEP_DHZ), 0);
  localparam int     PER_W   = $clog2(MAX_PER + 1);

  logic [PER_W-1:0]  period;
  logic              wr_ok;
  logic              same_val;
  logic              start_ramp;
  logic              hold_cancel;
  logic              accum_clear;
  logic [CODE_W-1:0] delta;
  logic              step;
  logic              done;
  logic              active;
  ramp_dir_t         dir_q;
  logic [CODE_W-1:0] tgt_q;

  assign wr_ok       = active_en && setpoint_wr;
  assign same_val    = setpoint == dac_code;
  assign start_ramp  = wr_ok && !same_val;
  assign hold_cancel = wr_ok && same_val;
  assign accum_clear = !active_en || hold_cancel;
  assign delta       = (setpoint > dac_code) ? setpoint - dac_code : dac_code - setpoint;
  assign ramp_busy   = active;

  vcm_period_rom #(
    .CLK_HZ  (CLK_HZ),
    .BASE_DHZ(BASE_DHZ),
    .STEP_DHZ(STEP_DHZ),
    .FREQ_W  (FREQ_W),
    .PER_W   (PER_W)
  ) u_rom (
    .code  (res_code),
    .period(period)
  );

  vcm_step_accum #(
    .CODE_W(CODE_W),
    .PER_W (PER_W)
  ) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_ramp),
    .clear    (accum_clear),
    .delta_in (delta),
    .period_in(period),
    .step     (step),
    .done     (done),
    .active   (active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= RAMP_UP;
      tgt_q <= '0;
    end else if (start_ramp) begin
      dir_q <= (setpoint > dac_code) ? RAMP_UP : RAMP_DOWN;
      tgt_q <= setpoint;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      dac_code <= '0;
    else if (!active_en)
      dac_code <= '0;
    else if (step && !wr_ok)
      dac_code <= (dir_q == RAMP_UP) ? dac_code + 1'b1 : dac_code - 1'b1;
  end

  // R7: leaving active mode zeroes the output and stops the ramp
  assert_off_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !active_en |=> dac_code == '0 && !ramp_busy);

  // R2: a changed write raises busy and holds the output on that edge
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active_en && setpoint_wr && setpoint != dac_code |=> ramp_busy && $stable(dac_code));

  // R3: at most one code of movement per cycle while active
  assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active_en |=> (dac_code == $past(dac_code)) || (dac_code == $past(dac_code) + 1'b1)
                  || (dac_code == $past(dac_code) - 1'b1));

  // R4: the final step lands on the latched target
  assert_lands_on_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && active_en && !setpoint_wr |=> dac_code == tgt_q && !ramp_busy);

  // R4: idle output holds
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active_en && !ramp_busy && !setpoint_wr |=> $stable(dac_code));

  // R6: an equal write leaves the block idle
  assert_equal_write_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active_en && setpoint_wr && setpoint == dac_code |=> !ramp_busy && $stable(dac_code));
endmodule

// File: tb/vcm_ramp_gen_test.sv
`timescale 1ns/1ps
module vcm_ramp_gen_test;
  localparam longint TB_CLK_HZ = 160000;
  localparam int NV = 5;
  // target, frequency code, hand-computed period floor(1600000/(500+4*code))
  localparam int V_TGT [NV] = '{512, 1023, 0, 300, 301};
  localparam int V_CODE[NV] = '{100, 255, 0, 200, 50};
  localparam int V_N   [NV] = '{1777, 1052, 3200, 1230, 2285};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       active_en = 1'b1;
  logic [9:0] setpoint = '0;
  logic       setpoint_wr = 1'b0;
  logic [7:0] res_code = '0;
  logic [9:0] dac_code;
  logic       ramp_busy;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  vcm_ramp_gen #(.CLK_HZ(TB_CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .active_en(active_en), .setpoint(setpoint),
    .setpoint_wr(setpoint_wr), .res_code(res_code), .dac_code(dac_code),
    .ramp_busy(ramp_busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Write target t with code c, then follow the ramp for 'stop' cycles.
  task automatic ramp(input int t, input int c, input int n, input int stop,
                      input string req);
    int s, d, e, bad_o, bad_b, fa, fe, fj;
    @(negedge clk);
    s = int'(dac_code);
    setpoint = 10'(t); res_code = 8'(c); setpoint_wr = 1'b1;
    @(negedge clk);
    setpoint_wr = 1'b0;
    chk(ramp_busy == 1'b1 && int'(dac_code) == s, "R2", "start edge busy/hold",
        int'(dac_code), s);
    d = (t > s) ? t - s : s - t;
    bad_o = 0; bad_b = 0; fa = 0; fe = 0; fj = 0;
    for (int j = 1; j <= stop; j++) begin
      @(negedge clk);
      if (j >= n) e = t;
      else e = (t > s) ? s + (d * j) / n : s - (d * j) / n;
      if (int'(dac_code) != e) begin
        if (bad_o == 0) begin fa = int'(dac_code); fe = e; fj = j; end
        bad_o++;
      end
      if (ramp_busy != (j < n)) bad_b++;
    end
    chk(bad_o == 0, req, $sformatf("trajectory (first miss at j=%0d)", fj), fa, fe);
    chk(bad_b == 0, "R2", "busy length mismatching cycles", bad_b, 0);
    if (stop >= n)
      chk(int'(dac_code) == t && !ramp_busy, "R4", "final code", int'(dac_code), t);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dac_code == 10'd0 && !ramp_busy, "R1", "reset state", int'(dac_code), 0);

    for (int i = 0; i < NV; i++)
      ramp(V_TGT[i], V_CODE[i], V_N[i], V_N[i] + 2, "R3");

    // R6: equal write while idle
    @(negedge clk);
    setpoint = 10'd301; res_code = 8'd0; setpoint_wr = 1'b1;
    @(negedge clk);
    setpoint_wr = 1'b0;
    chk(!ramp_busy && dac_code == 10'd301, "R6", "equal write idle", int'(ramp_busy), 0);
    repeat (5) @(negedge clk);
    chk(dac_code == 10'd301, "R6", "equal write hold", int'(dac_code), 301);

    // R5: retrigger mid-ramp from present output with a new code
    ramp(800, 255, 1052, 400, "R3");
    ramp(100, 0, 3200, 3202, "R5");

    // R6: equal write mid-ramp cancels and holds
    ramp(900, 200, 1230, 300, "R3");
    @(negedge clk);
    v = int'(dac_code);
    setpoint = 10'(v); setpoint_wr = 1'b1;
    @(negedge clk);
    setpoint_wr = 1'b0;
    chk(!ramp_busy && int'(dac_code) == v, "R6", "mid-ramp equal write", int'(dac_code), v);
    repeat (10) @(negedge clk);
    chk(int'(dac_code) == v && !ramp_busy, "R6", "mid-ramp cancel hold", int'(dac_code), v);

    // R7: leaving active mode mid-ramp
    ramp(700, 100, 1777, 200, "R3");
    @(negedge clk);
    active_en = 1'b0;
    @(negedge clk);
    chk(dac_code == 10'd0 && !ramp_busy, "R7", "disable forces zero", int'(dac_code), 0);
    setpoint = 10'd500; setpoint_wr = 1'b1;
    @(negedge clk);
    setpoint_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk(dac_code == 10'd0 && !ramp_busy, "R7", "write ignored when off", int'(dac_code), 0);

    // R8: re-enable rests at zero, next ramp starts from zero
    active_en = 1'b1;
    repeat (5) @(negedge clk);
    chk(dac_code == 10'd0 && !ramp_busy, "R8", "rest after enable", int'(dac_code), 0);
    ramp(40, 255, 1052, 1054, "R8");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule